// File: doc/BRIEF.md
# Dual-Master Bus Ownership Controller

This block decides which of two upstream I2C masters is connected to one shared downstream bus. Each master has its own control register. Writing a request to it marks that master's wish to take the bus, or to let go of it. The request is held pending and takes effect only when a STOP condition is seen on the bus of the master that wrote last. If both masters write requests before that STOP, the later write simply replaces the earlier one. Nothing is arbitrated.

Each master has a four-source interrupt status register and a matching mask register, and drives one active-low interrupt line. An ownership change flags "lost" to the previous owner and "gained" to the new owner. A downstream interrupt input is copied into both status registers. If the downstream bus sensor reports a busy bus at the moment of a switch, the new owner is flagged so that it can run its own recovery. Status bits are held until that master reads its status register.

The inputs are already decoded: register write and read strobes from the slave protocol engine, STOP events from each upstream side, the downstream busy sensor and the downstream interrupt. A parameter chooses the state after reset: channel 0 connected, or no channel connected.

Top module: `bus_owner_ctl`

## Requirements
- R1: `sel` is one-hot or zero at all times. `sel[0]` set means master 0 is connected and `sel[1]` set means master 1 is connected.
- R2: With reset low at a clock edge, the block takes its default state. With `START_CH0`=1 (the default), `sel`=01. All status and mask bits are 0, and `int_n`=11.
- R3: A control write carries 2 bits per master: 01 means take the bus, 10 means release it, and any other value means no request. A take request stays pending. `sel` changes only at the edge that samples a STOP on the last requester's bus. A write in the same cycle as a STOP waits for the next STOP.
- R4: A STOP on the other master's bus does not commit a pending request.
- R5: Of two requests written before a STOP, the later write wins. If both masters write in the same cycle, master 1 wins.
- R6: At the edge where ownership changes, the previous owner's status bit 1 (lost) is set and the new owner's status bit 2 (gained) is set.
- R7: `ds_int_n` low at an edge sets status bit 0 in both masters' status registers.
- R8: A mask bit set to 1 keeps its source from pulling that master's `int_n` low. The status bit is still recorded.
- R9: If `ds_busy` is high at the edge where a new owner is connected, that owner's status bit 3 (bus not idle) is set.
- R10: A release request from the current owner disconnects all channels (`sel`=00) at the committing STOP. A release request from a master that does not own the bus is ignored.
- R11: `stat_rdata` shows a master's status while `stat_rd` is high, and the status is cleared at that edge. A bit set in the same cycle is kept, because set wins over clear.
- R12: `ctl_rdata` per master is, from bit 3 down to bit 0: not-mine, mine, bus-off, bus-on.
- R13: A take request by the master that already owns the bus commits without changing `sel` and without raising any interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 2 | Control write strobe, one per master |
| ctl_req | input | 4 | Request code, [1:0] master 0, [3:2] master 1 |
| mask_wr | input | 2 | Mask write strobe, one per master |
| mask_wdata | input | 8 | Mask data, [3:0] master 0, [7:4] master 1 |
| stat_rd | input | 2 | Status read strobe, one per master (clears the status) |
| stop_seen | input | 2 | STOP condition detected on master bus, one per master |
| ds_busy | input | 1 | Downstream bus sensor, high when not idle |
| ds_int_n | input | 1 | Downstream interrupt, active low |
| sel | output | 2 | Channel connect, one-hot or zero |
| int_n | output | 2 | Interrupt line per master, active low |
| ctl_rdata | output | 8 | Control read value, [3:0] master 0, [7:4] master 1 |
| stat_rdata | output | 8 | Status read value, [3:0] master 0, [7:4] master 1 |

## Verification
A corrupted pending request shows up at `sel` at the very next STOP, in either of two ways. The wrong channel is connected, or a switch happens on the wrong master's STOP. A wrong set or clear in a status register shows on `int_n` one edge after the event or read that caused it. The bench walks ownership through every transition and checks `sel` and `int_n` after each edge. It reads `ctl_rdata` and `stat_rdata` directly to catch errors in the encoding and in the source bits, which the interrupt lines alone would hide.

// File: rtl/bo_pkg.sv
// Shared constants and types for the bus ownership controller.
// Assumes exactly two upstream masters; status sources are bit positions.
package bo_pkg;
    localparam int NM    = 2;   // upstream masters
    localparam int NSRC  = 4;   // interrupt sources per master
    localparam int REQW  = 2;   // request code width

    typedef enum logic [REQW-1:0] {
        REQ_NONE = 2'b00,
        REQ_TAKE = 2'b01,
        REQ_DROP = 2'b10,
        REQ_RSVD = 2'b11
    } req_e;

    localparam int SRC_DS    = 0;  // downstream interrupt
    localparam int SRC_LOST  = 1;  // ownership lost
    localparam int SRC_GAIN  = 2;  // ownership gained
    localparam int SRC_DIRTY = 3;  // bus non-idle at switch
endpackage

// File: rtl/bo_req.sv
// Pending-request tracker. Holds the most recent valid request and the
// master that wrote it; reports a commit when that master's STOP is seen.
// Assumes sel_cur is the registered ownership from the top.
module bo_req
    import bo_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NM-1:0]        ctl_wr,
    input  logic [NM*REQW-1:0]   ctl_req,
    input  logic [NM-1:0]        stop_seen,
    input  logic [NM-1:0]        sel_cur,
    output logic                 commit,
    output logic [NM-1:0]        sel_next
);
    logic          pend_q;
    logic          src_q;
    logic [NM-1:0] tgt_q;

    logic          wr_any;
    logic          wr_src;
    logic [NM-1:0] wr_tgt;

    // Decode this cycle's writes; the higher master index overrides.
    always_comb begin
        wr_any = 1'b0;
        wr_src = 1'b0;
        wr_tgt = '0;
        for (int m = 0; m < NM; m++) begin
            if (ctl_wr[m]) begin
                if (req_e'(ctl_req[m*REQW +: REQW]) == REQ_TAKE) begin
                    wr_any = 1'b1;
                    wr_src = 1'(m);
                    wr_tgt = NM'(1) << m;
                end else if (req_e'(ctl_req[m*REQW +: REQW]) == REQ_DROP
                             && sel_cur[m]) begin
                    wr_any = 1'b1;
                    wr_src = 1'(m);
                    wr_tgt = '0;
                end
            end
        end
    end

    assign commit   = pend_q && stop_seen[src_q];
    assign sel_next = tgt_q;

    // Hold the latest request; a new write replaces it, a commit retires it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            src_q  <= 1'b0;
            tgt_q  <= '0;
        end else if (wr_any) begin
            pend_q <= 1'b1;
            src_q  <= wr_src;
            tgt_q  <= wr_tgt;
        end else if (commit) begin
            pend_q <= 1'b0;
        end
    end

    // R10: a pending disconnect always came from a master that then owned the bus
    p_drop_has_owner_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && tgt_q == '0 && $past(rst_n) && $past(wr_any)) |-> ($past(sel_cur) != '0));
endmodule

// File: rtl/bo_irq.sv
// Per-master interrupt status and mask. Status bits are sticky until read;
// set wins over the read clear. The line is low while any unmasked bit is set.
module bo_irq
    import bo_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set,
    input  logic            mask_wr,
    input  logic [NSRC-1:0] mask_wdata,
    input  logic            rd,
    output logic [NSRC-1:0] stat,
    output logic            int_n
);
    logic [NSRC-1:0] stat_q;
    logic [NSRC-1:0] mask_q;

    // Record events; clear on read unless set in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= set | (rd ? '0 : stat_q);
        end
    end

    // Mask register, written by its own master only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_wr) begin
            mask_q <= mask_wdata;
        end
    end

    assign stat  = stat_q;
    assign int_n = ~|(stat_q & ~mask_q);

    // R11: a read with no new event leaves the status empty
    p_read_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rd) && $past(set) == '0) |-> (stat == '0));

    // R7: a downstream interrupt sample is recorded at the next edge
    p_ds_recorded_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(set[SRC_DS])) |-> stat[SRC_DS]);
endmodule

// File: rtl/bus_owner_ctl.sv
// Dual-master bus ownership controller top. Keeps the registered channel
// select, turns commits into ownership events and fans them out to the
// per-master interrupt units. Assumes STOP and access strobes are one-cycle
// pulses from the upstream protocol engines, synchronous to clk.
module bus_owner_ctl
    import bo_pkg::*;
#(
    parameter bit START_CH0 = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NM-1:0]        ctl_wr,
    input  logic [NM*REQW-1:0]   ctl_req,
    input  logic [NM-1:0]        mask_wr,
    input  logic [NM*NSRC-1:0]   mask_wdata,
    input  logic [NM-1:0]        stat_rd,
    input  logic [NM-1:0]        stop_seen,
    input  logic                 ds_busy,
    input  logic                 ds_int_n,
    output logic [NM-1:0]        sel,
    output logic [NM-1:0]        int_n,
    output logic [NM*NSRC-1:0]   ctl_rdata,
    output logic [NM*NSRC-1:0]   stat_rdata
);
    localparam logic [NM-1:0] SEL_RST = START_CH0 ? NM'(1) : '0;

    logic [NM-1:0] sel_q;
    logic          commit;
    logic [NM-1:0] sel_next;
    logic          change;

    bo_req u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_req   (ctl_req),
        .stop_seen (stop_seen),
        .sel_cur   (sel_q),
        .commit    (commit),
        .sel_next  (sel_next)
    );

    assign change = commit && (sel_next != sel_q);

    // Apply a committed ownership change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= SEL_RST;
        end else if (change) begin
            sel_q <= sel_next;
        end
    end

    assign sel = sel_q;

    for (genvar m = 0; m < NM; m++) begin : g_master
        logic [NSRC-1:0] set_m;
        logic [NSRC-1:0] stat_m;

        // Event sources for this master.
        always_comb begin
            set_m            = '0;
            set_m[SRC_DS]    = ~ds_int_n;
            set_m[SRC_LOST]  = change && sel_q[m];
            set_m[SRC_GAIN]  = change && sel_next[m];
            set_m[SRC_DIRTY] = change && sel_next[m] && ds_busy;
        end

        bo_irq u_irq (
            .clk        (clk),
            .rst_n      (rst_n),
            .set        (set_m),
            .mask_wr    (mask_wr[m]),
            .mask_wdata (mask_wdata[m*NSRC +: NSRC]),
            .rd         (stat_rd[m]),
            .stat       (stat_m),
            .int_n      (int_n[m])
        );

        assign stat_rdata[m*NSRC +: NSRC] = stat_m;
        assign ctl_rdata[m*NSRC +: NSRC]  = {~sel_q[m], sel_q[m], ~|sel_q, |sel_q};

        // R6: losing the channel always leaves a lost flag with the old owner
        p_lost_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(sel_q[m]) && !sel_q[m]) |-> stat_m[SRC_LOST]);
    end

    // R1: never more than one channel connected
    p_onehot_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_q));

    // R3: ownership moves only on an edge that sampled a STOP
    p_stop_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && sel_q != $past(sel_q)) |-> ($past(stop_seen) != '0));
endmodule

// File: tb/bus_owner_ctl_test.sv
module bus_owner_ctl_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] ctl_wr;
    logic [3:0] ctl_req;
    logic [1:0] mask_wr;
    logic [7:0] mask_wdata;
    logic [1:0] stat_rd;
    logic [1:0] stop_seen;
    logic       ds_busy;
    logic       ds_int_n;
    logic [1:0] sel;
    logic [1:0] int_n;
    logic [7:0] ctl_rdata;
    logic [7:0] stat_rdata;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    bus_owner_ctl uut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_req(ctl_req),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata), .stat_rd(stat_rd),
        .stop_seen(stop_seen), .ds_busy(ds_busy), .ds_int_n(ds_int_n),
        .sel(sel), .int_n(int_n), .ctl_rdata(ctl_rdata), .stat_rdata(stat_rdata)
    );

    // {wr, req, stop, busy, ds_int_n, rd, expected sel, expected int_n}
    localparam int NV = 19;
    localparam logic [15:0] VEC [NV] = '{
        {2'b10, 4'b0100, 2'b00, 1'b0, 1'b1, 2'b00, 2'b01, 2'b11}, // R3 m1 take pends
        {2'b00, 4'b0000, 2'b01, 1'b0, 1'b1, 2'b00, 2'b01, 2'b11}, // R4 wrong STOP
        {2'b00, 4'b0000, 2'b10, 1'b0, 1'b1, 2'b00, 2'b10, 2'b00}, // R3 R6 commit
        {2'b00, 4'b0000, 2'b00, 1'b0, 1'b1, 2'b11, 2'b10, 2'b11}, // R11 clear both
        {2'b01, 4'b0001, 2'b00, 1'b0, 1'b1, 2'b00, 2'b10, 2'b11}, // R5 m0 take
        {2'b10, 4'b0100, 2'b00, 1'b0, 1'b1, 2'b00, 2'b10, 2'b11}, // R5 m1 overwrites
        {2'b00, 4'b0000, 2'b01, 1'b0, 1'b1, 2'b00, 2'b10, 2'b11}, // R4 R5 m0 STOP no effect
        {2'b00, 4'b0000, 2'b10, 1'b0, 1'b1, 2'b00, 2'b10, 2'b11}, // R13 owner retake
        {2'b10, 4'b0100, 2'b00, 1'b0, 1'b1, 2'b00, 2'b10, 2'b11}, // R5 m1 take
        {2'b01, 4'b0001, 2'b00, 1'b0, 1'b1, 2'b00, 2'b10, 2'b11}, // R5 m0 last
        {2'b00, 4'b0000, 2'b01, 1'b1, 1'b1, 2'b00, 2'b01, 2'b00}, // R5 R6 R9 switch busy
        {2'b00, 4'b0000, 2'b00, 1'b0, 1'b1, 2'b10, 2'b01, 2'b10}, // R11 m1 read only
        {2'b00, 4'b0000, 2'b00, 1'b0, 1'b1, 2'b01, 2'b01, 2'b11}, // R11 m0 read
        {2'b10, 4'b1000, 2'b00, 1'b0, 1'b1, 2'b00, 2'b01, 2'b11}, // R10 non-owner release
        {2'b00, 4'b0000, 2'b10, 1'b0, 1'b1, 2'b00, 2'b01, 2'b11}, // R10 ignored
        {2'b01, 4'b0010, 2'b00, 1'b0, 1'b1, 2'b00, 2'b01, 2'b11}, // R10 owner release
        {2'b00, 4'b0000, 2'b01, 1'b0, 1'b1, 2'b00, 2'b00, 2'b10}, // R10 R6 all off
        {2'b00, 4'b0000, 2'b00, 1'b0, 1'b0, 2'b01, 2'b00, 2'b00}, // R7 R11 set wins
        {2'b00, 4'b0000, 2'b00, 1'b0, 1'b1, 2'b11, 2'b00, 2'b11}  // R11 clear
    };

    task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", what, act, exp);
        end
    endtask

    task automatic idle();
        ctl_wr = '0; ctl_req = '0; mask_wr = '0; mask_wdata = '0;
        stat_rd = '0; stop_seen = '0; ds_busy = 1'b0; ds_int_n = 1'b1;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle();
        tick(); tick(); tick();
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R2: default state after reset
        check("R2 sel after reset", {6'b0, sel}, 8'h01);
        check("R2 int_n after reset", {6'b0, int_n}, 8'h03);
        check("R2 status after reset", stat_rdata, 8'h00);

        for (int i = 0; i < NV; i++) begin
            {ctl_wr, ctl_req, stop_seen, ds_busy, ds_int_n, stat_rd} = VEC[i][15:4];
            tick();
            check($sformatf("R3-table step %0d sel", i), {6'b0, sel}, {6'b0, VEC[i][3:2]});
            check($sformatf("R6 table step %0d int_n", i), {6'b0, int_n}, {6'b0, VEC[i][1:0]});
        end
        idle();

        // R12: encoding with no owner
        check("R12 ctl m0 no owner", {4'b0, ctl_rdata[3:0]}, 8'h0A);
        check("R12 ctl m1 no owner", {4'b0, ctl_rdata[7:4]}, 8'h0A);

        // R3: write in the same cycle as STOP waits for the next STOP
        ctl_wr = 2'b10; ctl_req = 4'b0100; stop_seen = 2'b10;
        tick();
        idle();
        check("R3 same-cycle STOP waits", {6'b0, sel}, 8'h00);
        stop_seen = 2'b10; ds_busy = 1'b1;
        tick();
        idle();
        check("R3 next STOP commits", {6'b0, sel}, 8'h02);
        check("R6 gain without prior owner int_n", {6'b0, int_n}, 8'h01);
        check("R9 R6 m1 status gain+busy", {4'b0, stat_rdata[7:4]}, 8'h0C);
        check("R6 m0 status untouched", {4'b0, stat_rdata[3:0]}, 8'h00);
        check("R12 ctl m1 owner", {4'b0, ctl_rdata[7:4]}, 8'h05);
        check("R12 ctl m0 other owns", {4'b0, ctl_rdata[3:0]}, 8'h09);
        stat_rd = 2'b10;
        tick();
        idle();
        check("R11 read clears m1", {6'b0, int_n}, 8'h03);

        // R8: masked source records but does not pull the line
        mask_wr = 2'b01; mask_wdata = 8'h01;
        tick();
        idle();
        ds_int_n = 1'b0;
        tick();
        idle();
        check("R8 masked m0 stays high, R7 m1 low", {6'b0, int_n}, 8'h01);
        check("R8 masked bit still recorded", stat_rdata, 8'h11);
        stat_rd = 2'b11;
        tick();
        idle();
        check("R11 clear after mask test", {6'b0, int_n}, 8'h03);

        // R2: reset mid-run restores default
        do_reset();
        check("R2 sel after second reset", {6'b0, sel}, 8'h01);
        check("R2 status after second reset", stat_rdata, 8'h00);
        // R8: mask cleared by reset, downstream interrupt now reaches m0
        ds_int_n = 1'b0;
        tick();
        idle();
        check("R8 R2 mask reset, both lines low", {6'b0, int_n}, 8'h00);

        finish_run();
    end
endmodule